// File: doc/BRIEF.md
# Register-Width Aware Serial Configuration Slave

This block is the target side of a host-driven serial link for configuring a bank of control registers. The host selects the port with an active-low select, toggles a serial clock and moves bits over one, two or four data lanes. Each access opens with an instruction byte that gives a read or write flag and a register address. A data phase follows whose length is the byte width of that register, looked up inside the block. No byte count is ever sent.

All serial inputs are brought into the system clock domain through synchronizers. Serial clock edges are found there by edge detection, so the serial clock must run several times slower than the system clock. Writes go to an external register file as a single strobe with per-byte enables. Reads take the register file's combinational read data through a read address output.

A resync input, or releasing the select, ends the access at any point. Every data byte already fully shifted in is still written, and a byte that is only partly shifted in is dropped.

Top module: `cfg_serial_port`

## Requirements
- R1: The instruction byte is shifted in MSB first. Bit 7 set means read and clear means write, bits 4:0 are the register address, and bits 6:5 have no effect.
- R2: The data phase length in bytes is the width of the addressed register: address 0 is 1 byte, 1 is 3, 2 is 2, 3 is 3, 4 is 4, 5 and 6 are 2, 7 to 24 are 4, and 25 to 31 are 0. The edge after the last data bit starts a new instruction byte, with no need to release the select.
- R3: A write that completes raises wr_en for exactly one system clock, with wr_addr set to the address, wr_be set for every byte of the register and wr_data holding the value. The first data byte on the wire is the most significant byte of the register (byte lane width-1 of wr_data) and bits are MSB first.
- R4: In a read, rd_addr carries the address once the instruction is done. The register value from rd_data is driven MSB first, a new group of bits after each falling serial clock edge, for the host to sample on the next rising edge. The output enables are high only during the read data phase, and never while a write is committed.
- R5: lane_mode 00 is one lane, with input and output both on lane 0. 01 is one lane with input on lane 0 and output on lane 2. 10 moves two bits per edge on lanes 1:0, and 11 moves four bits per edge on lanes 3:0. The highest lane carries the most significant bit of each group.
- R6: A high resync during a write ends the access. If at least one byte was completed, exactly one wr_en pulse follows, with wr_be set only for the completed bytes (the top ones of the register). The partial byte is discarded and the other bytes of the register are unchanged. With no completed byte, nothing is written. The next bits form a new instruction.
- R7: Releasing the select during an access has the same effect as a resync, including the commit of completed bytes.
- R8: An instruction addressing a zero-width register causes no write and no output enable, and the next serial bits form a new instruction byte.
- R9: After reset, wr_en, sd_oe, sd_out and rd_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | Lane configuration, held steady while selected |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from host |
| resync | input | 1 | Abort and re-align to an instruction byte |
| sd_in | input | 4 | Serial data lanes, input side |
| sd_out | output | 4 | Serial data lanes, output side |
| sd_oe | output | 4 | Per-lane output enable |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | 5 | Register file write address |
| wr_data | output | 32 | Write value, register LSB in bits 7:0 |
| wr_be | output | 4 | Per-byte write enables |
| rd_addr | output | 5 | Register file read address |
| rd_data | input | 32 | Combinational read value of rd_addr |

## Verification
The assertions assume that lane_mode does not change while the port is selected, and that every serial clock half period lasts longer than the synchronizer delay, so that no serial clock edge is lost. They also assume that rd_data follows rd_addr in the same system cycle. The stimulus holds the mode fixed for each access, keeps every serial clock half period at six system clocks, and models the register file as a combinational array. Resync pulses and select releases are applied only while the serial clock is steady, so each abort falls between two serial clock edges.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int ADDR_W = 5;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    LM_ONE_BIDIR = 2'b00,
    LM_ONE_SPLIT = 2'b01,
    LM_TWO       = 2'b10,
    LM_FOUR      = 2'b11
  } lane_mode_e;

  // byte width of each register; zero marks an unmapped address
  function automatic logic [2:0] reg_bytes(input logic [ADDR_W-1:0] a);
    logic [2:0] w;
    case (a)
      5'd0:       w = 3'd1;
      5'd1:       w = 3'd3;
      5'd2:       w = 3'd2;
      5'd3:       w = 3'd3;
      5'd4:       w = 3'd4;
      5'd5, 5'd6: w = 3'd2;
      default:    w = (a <= 5'd24) ? 3'd4 : 3'd0;
    endcase
    return w;
  endfunction

  function automatic logic [2:0] bits_per_edge(input logic [1:0] m);
    logic [2:0] n;
    case (m)
      LM_FOUR: n = 3'd4;
      LM_TWO:  n = 3'd2;
      default: n = 3'd1;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/csp_rst_sync.sv
module csp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= src;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/csp_lane_io.sv
module csp_lane_io
  import csp_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [LANES-1:0] pin_in,
  input  logic [LANES-1:0] out_bits,
  input  logic             rd_active,
  output logic [LANES-1:0] in_bits,
  output logic [2:0]       nbits,
  output logic [LANES-1:0] pin_out,
  output logic [LANES-1:0] pin_oe
);
  logic [LANES-1:0] lane_used;

  always_comb begin
    nbits = bits_per_edge(mode);
    case (mode)
      LM_FOUR: begin
        in_bits   = pin_in;
        pin_out   = out_bits;
        lane_used = 4'b1111;
      end
      LM_TWO: begin
        in_bits   = {2'b00, pin_in[1:0]};
        pin_out   = {2'b00, out_bits[1:0]};
        lane_used = 4'b0011;
      end
      LM_ONE_SPLIT: begin
        in_bits   = {3'b000, pin_in[0]};
        pin_out   = {1'b0, out_bits[0], 2'b00};
        lane_used = 4'b0100;
      end
      default: begin
        in_bits   = {3'b000, pin_in[0]};
        pin_out   = {3'b000, out_bits[0]};
        lane_used = 4'b0001;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_oe
    assign pin_oe[g] = rd_active & lane_used[g];
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import csp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BYTES   = 4,
  localparam int DATA_W     = 8 * MAX_BYTES,
  localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           lane_mode,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 resync,
  input  logic [LANES-1:0]     sd_in,
  output logic [LANES-1:0]     sd_out,
  output logic [LANES-1:0]     sd_oe,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [MAX_BYTES-1:0] wr_be,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic [DATA_W-1:0]    rd_data
);
  localparam int SYN_W = LANES + 3;

  logic rst_n_i;
  csp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  logic [SYN_W-1:0] syn_q;
  logic             s_cs_n, s_sclk, s_resync;
  logic [LANES-1:0] s_sd;

  csp_sync #(
    .WIDTH   (SYN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({1'b1, 1'b0, 1'b0, {LANES{1'b0}}})
  ) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({cs_n, sclk, resync, sd_in}),
    .q     (syn_q)
  );
  assign {s_cs_n, s_sclk, s_resync, s_sd} = syn_q;

  // state
  phase_e               phase_q, phase_d;
  logic                 sclk_d_q;
  logic [2:0]           bitcnt_q, bitcnt_d;
  logic [CNT_W-1:0]     bytecnt_q, bytecnt_d;
  logic [7:0]           inshift_q, inshift_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0]     width_q, width_d;
  logic [DATA_W-1:0]    wbuf_q, wbuf_d;
  logic [DATA_W-1:0]    rdsh_q, rdsh_d;
  logic                 rd_first_q, rd_first_d;
  logic [LANES-1:0]     obits_q, obits_d;
  logic                 wr_en_q, wr_en_d;
  logic [ADDR_W-1:0]    wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0]    wr_data_q, wr_data_d;
  logic [MAX_BYTES-1:0] wr_be_q, wr_be_d;

  // lane mapping
  logic [LANES-1:0] in_bits;
  logic [2:0]       nbits;

  csp_lane_io u_lanes (
    .mode      (lane_mode),
    .pin_in    (s_sd),
    .out_bits  (obits_q),
    .rd_active (phase_q == PH_READ),
    .in_bits   (in_bits),
    .nbits     (nbits),
    .pin_out   (sd_out),
    .pin_oe    (sd_oe)
  );

  // edge detection and abort
  logic sclk_rise, sclk_fall, abort, step;
  assign sclk_rise = s_sclk & ~sclk_d_q;
  assign sclk_fall = ~s_sclk & sclk_d_q;
  assign abort     = s_cs_n | s_resync;
  assign step      = sclk_rise | sclk_fall | abort;

  // datapath helpers
  logic [7:0]           shifted;
  logic [3:0]           bit_sum;
  logic                 byte_done;
  logic [CNT_W-1:0]     byte_next;
  logic [CNT_W-1:0]     instr_w;
  logic [DATA_W-1:0]    wbuf_placed;
  logic [MAX_BYTES-1:0] be_part, be_full;
  logic [DATA_W-1:0]    rd_src;
  logic [DATA_W-1:0]    rd_aligned;
  logic [LANES-1:0]     rd_top;

  always_comb begin
    case (lane_mode)
      LM_FOUR: shifted = {inshift_q[3:0], in_bits[3:0]};
      LM_TWO:  shifted = {inshift_q[5:0], in_bits[1:0]};
      default: shifted = {inshift_q[6:0], in_bits[0]};
    endcase
    bit_sum   = {1'b0, bitcnt_q} + {1'b0, nbits};
    byte_done = bit_sum[3];
    byte_next = bytecnt_q + CNT_W'(1);
    instr_w   = CNT_W'(reg_bytes(shifted[ADDR_W-1:0]));
  end

  // place the just-finished byte: first byte goes to the top lane
  always_comb begin
    wbuf_placed = wbuf_q;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (i == int'(width_q) - 1 - int'(bytecnt_q))
        wbuf_placed[i*8 +: 8] = shifted;
    end
  end

  // enables for the completed bytes, anchored at the top of the register
  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) begin
      be_part[i] = (i < int'(width_q)) && (i + int'(bytecnt_q) >= int'(width_q));
      be_full[i] = (i < int'(width_q));
    end
  end

  // read path: align register MSB to the top of the shifter
  always_comb begin
    rd_aligned = rd_data << (8 * (MAX_BYTES - int'(width_q)));
    rd_src     = rd_first_q ? rd_aligned : rdsh_q;
    case (lane_mode)
      LM_FOUR: rd_top = rd_src[DATA_W-1 -: 4];
      LM_TWO:  rd_top = {2'b00, rd_src[DATA_W-1 -: 2]};
      default: rd_top = {3'b000, rd_src[DATA_W-1]};
    endcase
  end

  // next state
  always_comb begin
    phase_d    = phase_q;
    bitcnt_d   = bitcnt_q;
    bytecnt_d  = bytecnt_q;
    inshift_d  = inshift_q;
    addr_d     = addr_q;
    width_d    = width_q;
    wbuf_d     = wbuf_q;
    rdsh_d     = rdsh_q;
    rd_first_d = rd_first_q;
    obits_d    = obits_q;
    wr_en_d    = 1'b0;
    wr_addr_d  = wr_addr_q;
    wr_data_d  = wr_data_q;
    wr_be_d    = wr_be_q;

    if (abort) begin
      if (phase_q == PH_WRITE && bytecnt_q != '0) begin
        wr_en_d   = 1'b1;
        wr_addr_d = addr_q;
        wr_data_d = wbuf_q;
        wr_be_d   = be_part;
      end
      phase_d    = PH_INSTR;
      bitcnt_d   = '0;
      bytecnt_d  = '0;
      inshift_d  = '0;
      rd_first_d = 1'b0;
      obits_d    = '0;
    end else begin
      if (sclk_rise) begin
        inshift_d = shifted;
        bitcnt_d  = byte_done ? 3'd0 : bit_sum[2:0];
        if (byte_done) begin
          case (phase_q)
            PH_INSTR: begin
              addr_d    = shifted[ADDR_W-1:0];
              width_d   = instr_w;
              bytecnt_d = '0;
              wbuf_d    = '0;
              if (instr_w == '0)   phase_d = PH_INSTR;
              else if (shifted[7]) begin
                phase_d    = PH_READ;
                rd_first_d = 1'b1;
              end else             phase_d = PH_WRITE;
            end
            PH_WRITE: begin
              wbuf_d    = wbuf_placed;
              bytecnt_d = byte_next;
              if (byte_next == width_q) begin
                wr_en_d   = 1'b1;
                wr_addr_d = addr_q;
                wr_data_d = wbuf_placed;
                wr_be_d   = be_full;
                phase_d   = PH_INSTR;
                bytecnt_d = '0;
              end
            end
            PH_READ: begin
              bytecnt_d = byte_next;
              if (byte_next == width_q) begin
                phase_d   = PH_INSTR;
                bytecnt_d = '0;
                obits_d   = '0;
              end
            end
            default: phase_d = PH_INSTR;
          endcase
        end
      end
      if (sclk_fall && phase_q == PH_READ) begin
        obits_d    = rd_top;
        rdsh_d     = rd_src << nbits;
        rd_first_d = 1'b0;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q  <= PH_INSTR;
      sclk_d_q <= 1'b0;
      wr_en_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      sclk_d_q <= s_sclk;
      wr_en_q  <= wr_en_d;
    end
  end

  // datapath registers, advanced only on a serial event
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      bitcnt_q   <= '0;
      bytecnt_q  <= '0;
      inshift_q  <= '0;
      addr_q     <= '0;
      width_q    <= '0;
      wbuf_q     <= '0;
      rdsh_q     <= '0;
      rd_first_q <= 1'b0;
      obits_q    <= '0;
    end else if (step) begin
      bitcnt_q   <= bitcnt_d;
      bytecnt_q  <= bytecnt_d;
      inshift_q  <= inshift_d;
      addr_q     <= addr_d;
      width_q    <= width_d;
      wbuf_q     <= wbuf_d;
      rdsh_q     <= rdsh_d;
      rd_first_q <= rd_first_d;
      obits_q    <= obits_d;
    end
  end

  // write port registers, loaded only on a commit
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_be_q   <= '0;
    end else if (wr_en_d) begin
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      wr_be_q   <= wr_be_d;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign wr_be   = wr_be_q;
  assign rd_addr = addr_q;
endmodule

// File: rtl/csp_checker.sv
module csp_checker
  import csp_pkg::*;
#(
  parameter int MAX_BYTES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           lane_mode,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [MAX_BYTES-1:0] wr_be,
  input logic [LANES-1:0]     sd_oe
);
  logic [2:0] wr_w;
  assign wr_w = reg_bytes(wr_addr);

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3

  AST_BE_WITHIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_be >> wr_w) == '0)); // R2

  AST_NO_ZERO_LEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_w != 3'd0)); // R8

  AST_BE_TOP_ANCHORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_w != 3'd0) |-> wr_be[wr_w - 3'd1]); // R6

  AST_OE_IDLE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sd_oe == '0)); // R4

  AST_OE_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe != '0) |-> ($countones(sd_oe) == int'(bits_per_edge(lane_mode)))); // R5
endmodule

bind cfg_serial_port csp_checker #(.MAX_BYTES(MAX_BYTES)) u_csp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_mode (lane_mode),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_be     (wr_be),
  .sd_oe     (sd_oe)
);

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  md_r;
  logic        cs_n_r, sclk_r, rsy_r;
  logic [3:0]  sd_in_r;
  logic [3:0]  sd_out, sd_oe;
  logic        wr_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  wr_be;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfg_serial_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_mode (md_r),
    .cs_n      (cs_n_r),
    .sclk      (sclk_r),
    .resync    (rsy_r),
    .sd_in     (sd_in_r),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  // register file seen by the port, plus the bench's own prediction
  logic [31:0] rf     [32];
  logic [31:0] exp_rf [32];
  int          wr_n = 0;
  logic [4:0]  cap_addr;
  logic [31:0] cap_data;
  logic [3:0]  cap_be;

  function automatic logic [31:0] init_val(int i);
    return 32'hA5C3_0F1E ^ (32'h0101_0101 * i);
  endfunction

  function automatic logic [31:0] be_to_mask(logic [3:0] be);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  assign rd_data = rf[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= init_val(i);
    end else if (wr_en) begin
      wr_n     <= wr_n + 1;
      cap_addr <= wr_addr;
      cap_data <= wr_data;
      cap_be   <= wr_be;
      rf[wr_addr] <= (rf[wr_addr] & ~be_to_mask(wr_be)) | (wr_data & be_to_mask(wr_be));
    end
  end

  // width table per R2
  function automatic int wtab(logic [4:0] a);
    if (a == 0) return 1;
    if (a == 1 || a == 3) return 3;
    if (a == 2 || a == 5 || a == 6) return 2;
    if (a <= 24) return 4;
    return 0;
  endfunction

  function automatic int lanes(logic [1:0] m);
    return (m == 2'b11) ? 4 : (m == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic [3:0] oe_pat(logic [1:0] m);
    case (m)
      2'b00:   return 4'b0001;
      2'b01:   return 4'b0100;
      2'b10:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] lane_out(logic [1:0] m, logic [3:0] d);
    case (m)
      2'b00:   return {3'b0, d[0]};
      2'b01:   return {3'b0, d[2]};
      2'b10:   return {2'b0, d[1:0]};
      default: return d;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic edge_io(input logic [3:0] din, output logic [3:0] dout,
                         output logic [3:0] oe);
    sclk_r  = 1'b0;
    sd_in_r = din;
    repeat (HALF) @(negedge clk);
    dout   = sd_out;
    oe     = sd_oe;
    sclk_r = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // shift nedges groups of b (MSB first); collects output lanes into got
  task automatic send_byte(input logic [1:0] m, input logic [7:0] b, input int nedges,
                           input logic [3:0] oe_exp, inout logic [31:0] got,
                           inout int oe_bad);
    int L = lanes(m);
    logic [3:0] dout, oe, bits;
    for (int e = 0; e < nedges; e++) begin
      bits = 4'((b >> (8 - L * (e + 1))) & ((1 << L) - 1));
      edge_io(bits, dout, oe);
      got = (got << L) | 32'(lane_out(m, dout));
      if (oe !== oe_exp) oe_bad++;
    end
  endtask

  // one access: abort_k 0 none, 1 resync pulse, 2 select release
  task automatic xact(input logic [1:0] m, input logic rd, input logic [1:0] rsv,
                      input logic [4:0] a, input logic [31:0] val, input int nbytes,
                      input int xedges, input int abort_k, input bit end_cs,
                      input string req);
    int w = wtab(a);
    int L = lanes(m);
    int wr0 = wr_n;
    int oe_bad = 0;
    int comp;
    logic [31:0] got = '0, dummy = '0, mask, wmask;
    logic [3:0]  be_exp = '0;
    md_r = m;
    if (cs_n_r) begin
      cs_n_r = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    send_byte(m, {rd, rsv, a}, 8 / L, 4'b0000, dummy, oe_bad);
    if (w > 0) begin
      for (int j = 0; j < nbytes; j++)
        send_byte(m, rd ? 8'h00 : val[8*(w-1-j) +: 8], 8 / L,
                  rd ? oe_pat(m) : 4'b0000, got, oe_bad);
      if (xedges > 0)
        send_byte(m, rd ? 8'h00 : val[8*(w-1-nbytes) +: 8], xedges,
                  rd ? oe_pat(m) : 4'b0000, dummy, oe_bad);
    end
    if (abort_k == 1) begin
      rsy_r = 1'b1;
      repeat (HALF) @(negedge clk);
      rsy_r = 1'b0;
      repeat (HALF) @(negedge clk);
    end else if (abort_k == 2) begin
      cs_n_r = 1'b1;
      repeat (2 * HALF) @(negedge clk);
    end
    if (end_cs) begin
      sclk_r = 1'b0;
      repeat (HALF) @(negedge clk);
      cs_n_r = 1'b1;
    end
    repeat (10) @(negedge clk);

    chk(oe_bad == 0, req, $sformatf("output enable pattern, addr %0d", a),
        32'(oe_bad), 32'd0);
    comp = (nbytes < w) ? nbytes : w;
    for (int i = 0; i < 4; i++) if (i < w && i >= w - comp) be_exp[i] = 1'b1;
    if (!rd && comp > 0) begin
      chk(wr_n - wr0 == 1, req, "write strobe count", 32'(wr_n - wr0), 32'd1);
      chk(cap_addr == a, req, "write address", 32'(cap_addr), 32'(a));
      chk(cap_be == be_exp, req, "byte enables", 32'(cap_be), 32'(be_exp));
      mask = be_to_mask(be_exp);
      chk((cap_data & mask) == (val & mask), req, "write data",
          cap_data & mask, val & mask);
      exp_rf[a] = (exp_rf[a] & ~mask) | (val & mask);
    end else begin
      chk(wr_n == wr0, req, "no write expected", 32'(wr_n - wr0), 32'd0);
    end
    if (rd && w > 0 && nbytes >= w) begin
      wmask = (w == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * w)) - 32'd1);
      chk(got == (exp_rf[a] & wmask), req, $sformatf("read data addr %0d", a),
          got, exp_rf[a] & wmask);
    end
  endtask

  task automatic rd_full(input logic [1:0] m, input logic [4:0] a, input string req);
    xact(m, 1'b1, 2'b00, a, 32'h0, wtab(a), 0, 0, 1'b1, req);
  endtask

  task automatic wr_full(input logic [1:0] m, input logic [4:0] a,
                         input logic [31:0] v, input string req);
    xact(m, 1'b0, 2'b00, a, v, wtab(a), 0, 0, 1'b1, req);
  endtask

  initial begin
    int w, nb, xe, ab;
    logic [1:0] m;
    logic [4:0] a;
    logic rd;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 32; i++) exp_rf[i] = init_val(i);
    rst_n = 1'b0; md_r = 2'b00; cs_n_r = 1'b1; sclk_r = 1'b0;
    rsy_r = 1'b0; sd_in_r = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R9 reset state
    chk(wr_en == 1'b0, "R9", "wr_en after reset", 32'(wr_en), 32'd0);
    chk(sd_oe == 4'h0, "R9", "sd_oe after reset", 32'(sd_oe), 32'd0);
    chk(sd_out == 4'h0, "R9", "sd_out after reset", 32'(sd_out), 32'd0);
    chk(rd_addr == 5'd0, "R9", "rd_addr after reset", 32'(rd_addr), 32'd0);

    // R3 full write, R4 read back
    wr_full(2'b00, 5'd1, 32'h0012_3456, "R3");
    rd_full(2'b00, 5'd1, "R4");
    rd_full(2'b00, 5'd0, "R4");

    // R5 every lane mode, write and read
    for (int k = 0; k < 4; k++) begin
      wr_full(2'(k), 5'(8 + k), 32'hC0DE_0000 | 32'(k * 32'h1111), "R5");
      rd_full(2'(k), 5'(8 + k), "R5");
    end

    // R2 back-to-back accesses without releasing the select
    xact(2'b10, 1'b0, 2'b00, 5'd2, 32'h0000_BEEF, 2, 0, 0, 1'b0, "R2");
    xact(2'b10, 1'b0, 2'b00, 5'd3, 32'h00AB_CDEF, 3, 0, 0, 1'b0, "R2");
    xact(2'b10, 1'b1, 2'b00, 5'd3, 32'h0, 3, 0, 0, 1'b1, "R2");

    // R6 resync after two full bytes and a partial one
    xact(2'b00, 1'b0, 2'b00, 5'd4, 32'h1122_3344, 2, 3, 1, 1'b1, "R6");
    rd_full(2'b00, 5'd4, "R6");
    // R6 resync with no completed byte
    xact(2'b10, 1'b0, 2'b00, 5'd7, 32'hFFFF_FFFF, 0, 3, 1, 1'b1, "R6");
    rd_full(2'b10, 5'd7, "R6");

    // R7 select release after one byte plus one group
    xact(2'b11, 1'b0, 2'b00, 5'd10, 32'h9876_5432, 1, 1, 2, 1'b1, "R7");
    rd_full(2'b11, 5'd10, "R7");

    // R8 unmapped address, next byte is an instruction
    xact(2'b00, 1'b1, 2'b00, 5'd27, 32'h0, 0, 0, 0, 1'b0, "R8");
    xact(2'b00, 1'b0, 2'b00, 5'd5, 32'h0000_7E81, 2, 0, 0, 1'b1, "R8");

    // R1 reserved instruction bits set
    xact(2'b01, 1'b0, 2'b11, 5'd6, 32'h0000_5AA5, 2, 0, 0, 1'b1, "R1");
    xact(2'b01, 1'b1, 2'b10, 5'd6, 32'h0, 2, 0, 0, 1'b1, "R1");

    // constrained random accesses
    for (int t = 0; t < 60; t++) begin
      m  = 2'($urandom % 4);
      a  = 5'($urandom % 32);
      rd = 1'($urandom % 2);
      w  = wtab(a);
      nb = w; xe = 0; ab = 0;
      if (w > 0 && ($urandom % 4) == 0) begin
        nb = int'($urandom % w);
        xe = int'($urandom % (8 / lanes(m)));
        ab = 1 + int'($urandom % 2);
      end
      xact(m, rd, 2'($urandom % 4), a, $urandom, nb, xe, ab, 1'b1,
           rd ? "R4" : "R3");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule